// File: doc/BRIEF.md
# Multiphase Activation Sequencer

This block decides which phases of an N-phase buck converter receive a start request. It is paced by a slow activation tick taken from a faster system clock. On each tick it turns its inputs into one-cycle start pulses, one per phase. The control that switches a single phase is outside this block. Each phase reports back through a busy line while its own cycle is running.

In normal mode a token rotates around the phases in ascending circular order. On a tick where the regulator asks for energy, the token's phase starts and the token moves on. A busy phase is skipped, so the next free phase in the ring starts. This lets a new phase begin while earlier ones are still active. In high-load mode the token is ignored and every free phase starts on the same tick. The token position is kept, so normal mode continues where it stopped.

Top module: `phase_sequencer`

## Requirements
- R1: After reset no start pulse is driven, and the first normal-mode activation goes to phase 0 when it is free.
- R2: Start pulses appear only in the clock cycle that follows a cycle with `act_tick` high, and each lasts one cycle.
- R3: In normal mode with `need_energy` high and no phase busy, successive ticks start phases 0, 1, ..., N-1, then wrap back to phase 0.
- R4: In normal mode at most one phase is started per tick.
- R5: In normal mode a tick with `need_energy` low starts no phase and leaves the token where it was.
- R6: In normal mode a busy phase is skipped. The first free phase found from the token position onward in circular order starts, and the token moves to the phase after it.
- R7: In normal mode, when every phase is busy, a tick starts nothing and the token is held.
- R8: When `high_load` is high, a tick starts every free phase at once, whatever the state of `need_energy`.
- R9: In high-load mode a busy phase is never started again.
- R10: Ticks in high-load mode do not move the token. The next normal-mode activation resumes at the phase after the last one started in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_tick | input | 1 | One-cycle phase-activation tick |
| need_energy | input | 1 | Under-voltage seen: the regulator asks for energy |
| high_load | input | 1 | High-load mode: start all free phases together |
| busy | input | NPH | Bit i high while phase i is still running its cycle |
| fire | output | NPH | Bit i pulses for one cycle to start phase i |

## Verification
The main function is first driven with all phases free and energy requested, to show that the token walks the ring in order and wraps. It is then driven with energy withheld, to separate "tick seen" from "energy needed". Busy masks that cover the token's phase, several phases across the wrap point, and all phases show skipping and holding, and show that the token lands past the chosen phase rather than past the token position. High-load ticks, with and without busy phases and followed by a return to normal mode, separate a fire-all override that leaves the token alone from one that disturbs it.

// File: rtl/phs_pkg.sv
// Shared types and helpers for the multiphase activation sequencer.
// Assumes all phase indices are below the phase count passed in.
package phs_pkg;

    typedef enum logic {
        MODE_NORMAL   = 1'b0,
        MODE_HIGHLOAD = 1'b1
    } phs_mode_e;

    // Circular add: (a + b) mod n for a, b < n.
    function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned n);
        int unsigned s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/phs_rot_pick.sv
// Rotating first-free finder: starting at position `start`, searches the
// phases in ascending circular order and returns the first one not busy.
// Assumes start < NPH. Purely combinational.
module phs_rot_pick #(
    parameter int NPH = 4,
    parameter int PW  = 2
) (
    input  logic [PW-1:0]  start,
    input  logic [NPH-1:0] busy,
    output logic           found,
    output logic [PW-1:0]  pick
);
    // Scan the ring from the token, first free phase wins.
    always_comb begin
        int unsigned idx;
        found = 1'b0;
        pick  = '0;
        idx   = 0;
        for (int off = 0; off < NPH; off++) begin
            idx = phs_pkg::wrap_add(32'(start), 32'(off), 32'(NPH));
            if (!found && !busy[idx]) begin
                found = 1'b1;
                pick  = PW'(idx);
            end
        end
    end
endmodule

// File: rtl/phs_token.sv
// Token position register: holds the phase that gets the next normal-mode
// activation. Starts at phase 0 and loads a new position only on advance.
module phs_token #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [PW-1:0] next_pos,
    output logic [PW-1:0] pos
);
    // Hold or move the token.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= '0;
        else if (advance) pos <= next_pos;
    end
endmodule

// File: rtl/phs_fire_gen.sv
// Start-pulse registers: one flop per phase turns a same-cycle request into
// a registered one-cycle pulse. Assumes req is only high on tick cycles.
module phs_fire_gen #(
    parameter int NPH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] req,
    output logic [NPH-1:0] fire
);
    for (genvar g = 0; g < NPH; g++) begin : g_ph
        // Register the start request of phase g.
        always_ff @(posedge clk) begin
            if (!rst_n) fire[g] <= 1'b0;
            else        fire[g] <= req[g];
        end
    end
endmodule

// File: rtl/phase_sequencer.sv
// Multiphase activation sequencer (top). In normal mode it starts the first
// free phase from the token and moves the token past it. In high-load mode it
// starts every free phase and leaves the token alone. Assumes act_tick is a
// single-cycle pulse in the clk domain and NPH >= 2.
module phase_sequencer #(
    parameter int NPH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act_tick,
    input  logic           need_energy,
    input  logic           high_load,
    input  logic [NPH-1:0] busy,
    output logic [NPH-1:0] fire
);
    import phs_pkg::*;

    localparam int PW = (NPH > 1) ? $clog2(NPH) : 1;

    phs_mode_e      mode;
    logic [PW-1:0]  tok_pos;
    logic [PW-1:0]  tok_next;
    logic [PW-1:0]  pick;
    logic           found;
    logic           advance;
    logic [NPH-1:0] req;

    // Select the operating mode from the high-load flag.
    assign mode = high_load ? MODE_HIGHLOAD : MODE_NORMAL;

    phs_rot_pick #(.NPH(NPH), .PW(PW)) u_pick (
        .start (tok_pos),
        .busy  (busy),
        .found (found),
        .pick  (pick)
    );

    // Token goes to the phase after the one just started.
    assign tok_next = PW'(wrap_add(32'(pick), 32'd1, 32'(NPH)));

    // Move the token only on a normal-mode activation that found a free phase.
    assign advance = act_tick && (mode == MODE_NORMAL) && need_energy && found;

    phs_token #(.PW(PW)) u_tok (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .next_pos (tok_next),
        .pos      (tok_pos)
    );

    // Build the per-phase start requests for this tick.
    always_comb begin
        req = '0;
        if (act_tick) begin
            case (mode)
                MODE_HIGHLOAD: req = ~busy;
                default: if (need_energy && found) req[pick] = 1'b1;
            endcase
        end
    end

    phs_fire_gen #(.NPH(NPH)) u_fire (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .fire  (fire)
    );
endmodule

// File: rtl/phase_sequencer_chk.sv
// Property checker for the activation sequencer, bound to every instance.
// Observes ports only.
module phase_sequencer_chk #(
    parameter int NPH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           act_tick,
    input logic           need_energy,
    input logic           high_load,
    input logic [NPH-1:0] busy,
    input logic [NPH-1:0] fire
);
    // R2
    no_fire_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_tick |=> (fire == '0));

    // R4
    single_start_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_tick && !high_load) |=> $onehot0(fire));

    // R5
    no_start_without_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_tick && !high_load && !need_energy) |=> (fire == '0));

    // R6
    busy_never_started_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_tick |=> ((fire & $past(busy)) == '0));

    // R7
    all_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_tick && !high_load && (busy == '1)) |=> (fire == '0));

    // R8
    highload_all_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_tick && high_load) |=> (fire == ~$past(busy)));
endmodule

bind phase_sequencer phase_sequencer_chk #(.NPH(NPH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_tick    (act_tick),
    .need_energy (need_energy),
    .high_load   (high_load),
    .busy        (busy),
    .fire        (fire)
);

// File: tb/phase_sequencer_test.sv
module phase_sequencer_test;
    localparam int NPH = 4;
    localparam int NV  = 15;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           act_tick = 1'b0;
    logic           need_energy = 1'b0;
    logic           high_load = 1'b0;
    logic [NPH-1:0] busy = '0;
    logic [NPH-1:0] fire;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    phase_sequencer #(.NPH(NPH)) uut (
        .clk(clk), .rst_n(rst_n), .act_tick(act_tick), .need_energy(need_energy),
        .high_load(high_load), .busy(busy), .fire(fire)
    );

    // Row: {tick, high_load, need_energy, busy[3:0], expected fire[3:0]}
    localparam logic [10:0] VEC [NV] = '{
        {3'b101, 4'b0000, 4'b0001},  // R1 first start at phase 0
        {3'b101, 4'b0000, 4'b0010},  // R3
        {3'b001, 4'b0000, 4'b0000},  // R2 no tick
        {3'b101, 4'b0000, 4'b0100},  // R3
        {3'b101, 4'b0000, 4'b1000},  // R3 last phase
        {3'b100, 4'b0000, 4'b0000},  // R5 no energy asked
        {3'b101, 4'b0001, 4'b0010},  // R6 token phase busy (proves wrap and R5 hold)
        {3'b101, 4'b1100, 4'b0001},  // R6 skip across wrap
        {3'b101, 4'b1111, 4'b0000},  // R7 all busy
        {3'b101, 4'b0000, 4'b0010},  // R7 token held
        {3'b110, 4'b0000, 4'b1111},  // R8 all fire, need low
        {3'b111, 4'b0101, 4'b1010},  // R9 busy not restarted
        {3'b010, 4'b0000, 4'b0000},  // R2 high load without tick
        {3'b101, 4'b0000, 4'b0100},  // R10 resumes after phase 1
        {3'b101, 4'b0000, 4'b1000}   // R10
    };

    string vtag [NV];

    task automatic check(string tag, logic [NPH-1:0] exp);
        n_cmp++;
        if (fire !== exp) begin
            n_bad++;
            $display("FAIL %s: fire=%b expected=%b", tag, fire, exp);
        end
    endtask

    // Drive one cycle at a negedge, then sample one cycle later.
    task automatic step(logic t, logic h, logic e, logic [NPH-1:0] b);
        act_tick = t; high_load = h; need_energy = e; busy = b;
        @(negedge clk);
        act_tick = 1'b0;
    endtask

    initial begin
        vtag = '{"R1", "R3", "R2", "R3", "R3", "R5", "R6", "R6", "R7", "R7",
                 "R8", "R9", "R2", "R10", "R10"};
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
            check(vtag[i], VEC[i][3:0]);
        end
        // R2: pulse lasts one cycle
        @(negedge clk);
        check("R2", '0);
        // R1: reset mid-run returns token to phase 0
        step(1'b1, 1'b0, 1'b1, 4'b0000);
        check("R3", 4'b0001);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 4'b0000);
        check("R1", 4'b0001);
        // R6: only the last phase free, from token at phase 1
        step(1'b1, 1'b0, 1'b1, 4'b0111);
        check("R6", 4'b1000);
        step(1'b1, 1'b0, 1'b1, 4'b0000);
        check("R6", 4'b0001);
        // R8: all busy in high load starts nothing
        step(1'b1, 1'b1, 1'b1, 4'b1111);
        check("R8", 4'b0000);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule